// File: doc/BRIEF.md
# Tile 2D FFT Beamformer

This block forms many simultaneous beams from one square tile of 8x8 antenna elements, for one polarisation and one frequency subband. A complete snapshot of the 64 complex element samples arrives in a single cycle. The block can scale each sample by a per-element taper coefficient to pull the sidelobes below the level of a uniform aperture. It then computes the two-dimensional spatial DFT of the tile as eight 8-point FFTs along the rows, followed by eight 8-point FFTs along the columns. Of the 64 resulting beams, eight chosen through a programmable table are streamed out, one per cycle, each tagged with its beam index.

A second polarisation uses a second instance. Both the taper coefficients and the beam table are written through simple write ports between frames. An optional divide-by-two after every radix-2 stage bounds word growth when the input has large amplitude.

Top module: `tile_beamformer`

## Requirements
- R1: Reset clears `out_valid` and `frame_done`. After reset, beam-table entry i holds beam index i, and every taper coefficient holds 128, which is unity gain.
- R2: `frame_valid` is accepted when the block is idle. Counting the accepting clock edge as edge 0, the selected beams appear on edges 17 to 24 with `out_valid` high. They come in table-entry order 0 to 7, one per cycle, and no other cycle has `out_valid` high.
- R3: `out_index` equals the table entry in use. Index bits [5:3] give the row frequency kr and bits [2:0] give the column frequency kc.
- R4: Element (r,c) is carried in bits [(8r+c)*4 +: 4] of `frame_re` and `frame_im` as 4-bit two's complement. With scaling off, a beam equals X(kr,kc) = Σ x(r,c)·exp(−j2π(kr·r + kc·c)/8) to within ±8 LSB on each of the real and imaginary parts.
- R5: With `scale_en` high at acceptance, each of the six radix-2 stages halves its result, rounding down. The beam then equals X(kr,kc)/64 to within ±6 LSB on each part.
- R6: With `win_en` high at acceptance, each sample part becomes floor(x·w/128), where w is the unsigned 8-bit coefficient of that element. With `win_en` low, the raw samples are used.
- R7: When `win_we` is high, `win_data` is written into the coefficient of element `win_addr`, where the element number is 8r+c.
- R8: When `sel_we` is high, `sel_data` is written into beam-table entry `sel_addr`. Later frames output the beams in the updated entries.
- R9: `frame_done` is high for exactly one cycle, the cycle right after the eighth beam, and `out_valid` is low in that cycle.
- R10: `frame_valid` is ignored on edges 1 to 25 after an acceptance. A new frame can be accepted from edge 26 on, so holding `frame_valid` high streams frames back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_valid | input | 1 | A new element snapshot is present |
| frame_re | input | 256 | Real parts of the 64 element samples |
| frame_im | input | 256 | Imaginary parts of the 64 element samples |
| win_en | input | 1 | Apply the taper to this frame |
| scale_en | input | 1 | Halve after every radix-2 stage for this frame |
| win_we | input | 1 | Taper coefficient write strobe |
| win_addr | input | 6 | Element number of the coefficient being written |
| win_data | input | 8 | Unsigned coefficient, 128 = unity |
| sel_we | input | 1 | Beam-table write strobe |
| sel_addr | input | 3 | Beam-table entry being written |
| sel_data | input | 6 | Beam index {kr, kc} |
| out_valid | output | 1 | A beam is on the output |
| out_re | output | 16 | Beam real part, two's complement |
| out_im | output | 16 | Beam imaginary part, two's complement |
| out_index | output | 6 | Index of the beam on the output |
| frame_done | output | 1 | One-cycle pulse after the last beam of a frame |

## Verification
The first pattern is an impulse at the tile corner. It must give the same value on every beam, which separates a correct beam-index mapping and output order from mistakes in the butterfly arithmetic. An impulse away from the corner and plane-wave phase ramps at several (kr,kc) pairs follow. A ramp puts all its energy in one beam, so a swapped row and column, a conjugated twiddle or a wrong bit reversal moves or smears the peak and is caught against a behavioural DFT. A random snapshot under a position-dependent taper shows whether each element is read with its own coefficient. A half-gain taper tests the rounding of the product, and a scaled frame tests the per-stage halving. Finally, `frame_valid` is held high across frames with changing data, which shows whether requests during a frame are dropped and the next frame starts exactly on time.

// File: rtl/bf_pkg.sv
// Package: shared sizes, the complex sample type and the 8-point twiddle rotation.
// Assumes an 8-point transform per dimension; rot() covers twiddle indices 0..3 of W8.
package bf_pkg;
    localparam int N    = 8;                 // elements per tile side
    localparam int LOGN = $clog2(N);         // radix-2 stages per dimension
    localparam int NE   = N * N;             // elements per tile
    localparam int EW   = $clog2(NE);        // element / beam index width
    localparam int SW   = 4;                 // sample part width
    localparam int CW   = 8;                 // taper coefficient width
    localparam int WF   = CW - 1;            // coefficient fraction bits (128 = 1.0)
    localparam int DW   = 16;                // internal and output word width
    localparam int XW   = DW + 1;            // butterfly sum width
    localparam int TWF  = 14;                // twiddle fraction bits
    localparam int PW   = DW + TWF + 2;      // twiddle product width

    localparam logic signed [PW-1:0] TW_C   = PW'(11585);          // cos(pi/4) in Q14
    localparam logic signed [PW-1:0] TW_RND = PW'(1) <<< (TWF - 1); // round-half-up offset

    typedef struct packed {
        logic signed [DW-1:0] re;
        logic signed [DW-1:0] im;
    } cplx_t;

    // Reverse the low LOGN bits of v.
    function automatic int bitrev(int v);
        int r;
        r = 0;
        for (int b = 0; b < LOGN; b++) begin
            r = (r << 1) | ((v >> b) & 1);
        end
        return r;
    endfunction

    // Multiply x by W8^t = exp(-j*2*pi*t/8) for t in 0..3, with rounding.
    function automatic cplx_t rot(cplx_t x, int t);
        logic signed [PW-1:0] a, b, pa, pb;
        cplx_t y;
        a  = PW'(x.re);
        b  = PW'(x.im);
        pa = '0;
        pb = '0;
        y  = x;
        case (t)
            1: begin
                pa   = (a + b) * TW_C;
                pb   = (b - a) * TW_C;
                y.re = DW'((pa + TW_RND) >>> TWF);
                y.im = DW'((pb + TW_RND) >>> TWF);
            end
            2: begin
                y.re = x.im;
                y.im = -x.re;
            end
            3: begin
                pa   = (b - a) * TW_C;
                pb   = -((a + b) * TW_C);
                y.re = DW'((pa + TW_RND) >>> TWF);
                y.im = DW'((pb + TW_RND) >>> TWF);
            end
            default: y = x;
        endcase
        return y;
    endfunction
endpackage

// File: rtl/bf_window.sv
// Module: taper coefficient store and per-row sample weighting.
// Holds one unsigned coefficient per element (reset to unity). For the row being
// transformed it presents eight weighted, sign-extended samples. Coefficients are
// written only between frames.
module bf_window
    import bf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [EW-1:0]        waddr,
    input  logic [CW-1:0]        wdata,
    input  logic                 en,
    input  logic [LOGN-1:0]      row,
    input  logic signed [SW-1:0] raw_re [N],
    input  logic signed [SW-1:0] raw_im [N],
    output cplx_t                dout   [N]
);
    localparam int PRW = SW + CW + 1;

    logic [CW-1:0] coef_q [NE];

    // Coefficient store: unity after reset, single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NE; e++) coef_q[e] <= CW'(1 << WF);
        end else if (we) begin
            coef_q[waddr] <= wdata;
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_col
        logic [CW-1:0]         w;
        logic signed [PRW-1:0] pr, pi;

        // Weight one sample of the row, or pass it through in bypass.
        always_comb begin
            w  = coef_q[{row, LOGN'(c)}];
            pr = PRW'(raw_re[c]) * $signed({1'b0, w});
            pi = PRW'(raw_im[c]) * $signed({1'b0, w});
            if (en) begin
                dout[c].re = DW'(pr >>> WF);
                dout[c].im = DW'(pi >>> WF);
            end else begin
                dout[c].re = DW'(raw_re[c]);
                dout[c].im = DW'(raw_im[c]);
            end
        end
    end
endmodule

// File: rtl/bf_fft8.sv
// Module: combinational N-point radix-2 decimation-in-time FFT.
// Inputs are in natural order and are bit-reversed internally. Outputs are in
// natural order. When scale is high, every stage halves its results (floor).
// Assumes the word width covers the growth of the unscaled path.
module bf_fft8
    import bf_pkg::*;
(
    input  logic  scale,
    input  cplx_t din  [N],
    output cplx_t dout [N]
);
    cplx_t st [LOGN+1][N];

    for (genvar i = 0; i < N; i++) begin : g_in
        assign st[0][i] = din[bitrev(i)];
        assign dout[i]  = st[LOGN][i];
    end

    for (genvar s = 0; s < LOGN; s++) begin : g_stage
        localparam int H = 1 << s;
        for (genvar i = 0; i < N; i++) begin : g_pair
            if (((i / H) % 2) == 0) begin : g_bfly
                localparam int P = i + H;
                localparam int T = (i % H) * (N / (2 * H));
                cplx_t                tw, y0, y1;
                logic signed [XW-1:0] sr, si, dr, di;

                // One butterfly: rotate the lower leg, add and subtract, optional halving.
                always_comb begin
                    tw = rot(st[s][P], T);
                    sr = XW'(st[s][i].re) + XW'(tw.re);
                    si = XW'(st[s][i].im) + XW'(tw.im);
                    dr = XW'(st[s][i].re) - XW'(tw.re);
                    di = XW'(st[s][i].im) - XW'(tw.im);
                    if (scale) begin
                        y0.re = DW'(sr >>> 1);
                        y0.im = DW'(si >>> 1);
                        y1.re = DW'(dr >>> 1);
                        y1.im = DW'(di >>> 1);
                    end else begin
                        y0.re = DW'(sr);
                        y0.im = DW'(si);
                        y1.re = DW'(dr);
                        y1.im = DW'(di);
                    end
                end

                assign st[s+1][i] = y0;
                assign st[s+1][P] = y1;
            end
        end
    end
endmodule

// File: rtl/bf_beam_sel.sv
// Module: programmable table of the beams to emit.
// Entry i resets to beam index i. Writes are expected between frames only.
module bf_beam_sel
    import bf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [LOGN-1:0] waddr,
    input  logic [EW-1:0]   wdata,
    input  logic [LOGN-1:0] raddr,
    output logic [EW-1:0]   rdata
);
    logic [EW-1:0] tab_q [N];

    // Table store: identity after reset, single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) tab_q[i] <= EW'(i);
        end else if (we) begin
            tab_q[waddr] <= wdata;
        end
    end

    assign rdata = tab_q[raddr];
endmodule

// File: rtl/tile_beamformer.sv
// Module: tile 2D FFT beamformer, top level.
// Accepts one 64-element snapshot in a cycle. It then runs eight row FFTs into a
// transpose buffer and eight column FFTs in place on that buffer, sharing one
// 8-point FFT between the two passes. Finally it streams eight beams chosen by
// the beam table, followed by a done pulse. Mode bits are captured when the
// frame is accepted. Table and taper writes are expected only while idle.
module tile_beamformer
    import bf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [NE*SW-1:0]    frame_re,
    input  logic [NE*SW-1:0]    frame_im,
    input  logic                win_en,
    input  logic                scale_en,
    input  logic                win_we,
    input  logic [EW-1:0]       win_addr,
    input  logic [CW-1:0]       win_data,
    input  logic                sel_we,
    input  logic [LOGN-1:0]     sel_addr,
    input  logic [EW-1:0]       sel_data,
    output logic                out_valid,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im,
    output logic [EW-1:0]       out_index,
    output logic                frame_done
);
    typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_OUT, S_DONE} state_t;

    localparam logic [LOGN-1:0] LAST = LOGN'(N - 1);

    state_t               state_q;
    logic [LOGN-1:0]      cnt_q;
    logic                 win_q, scale_q;
    logic                 accept;
    logic signed [SW-1:0] raw_re_q [NE];
    logic signed [SW-1:0] raw_im_q [NE];
    logic signed [SW-1:0] row_re   [N];
    logic signed [SW-1:0] row_im   [N];
    cplx_t                tbuf_q   [N][N];
    cplx_t                win_row  [N];
    cplx_t                fft_in   [N];
    cplx_t                fft_out  [N];
    logic [EW-1:0]        sel_idx;
    cplx_t                beam;

    assign accept = (state_q == S_IDLE) && frame_valid;

    // Sequencer: idle, row pass, column pass, beam output, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    cnt_q <= '0;
                    if (frame_valid) state_q <= S_ROW;
                end
                S_ROW: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= S_COL;
                end
                S_COL: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= S_OUT;
                end
                S_OUT: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= S_DONE;
                end
                default: begin
                    cnt_q   <= '0;
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    // Mode capture: the mode bits hold for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= 1'b0;
            scale_q <= 1'b0;
        end else if (accept) begin
            win_q   <= win_en;
            scale_q <= scale_en;
        end
    end

    // Snapshot capture: hold the raw element samples for the row pass.
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int e = 0; e < NE; e++) begin
                raw_re_q[e] <= frame_re[e*SW +: SW];
                raw_im_q[e] <= frame_im[e*SW +: SW];
            end
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_rowsel
        assign row_re[c] = raw_re_q[{cnt_q, LOGN'(c)}];
        assign row_im[c] = raw_im_q[{cnt_q, LOGN'(c)}];
    end

    bf_window u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (win_we),
        .waddr  (win_addr),
        .wdata  (win_data),
        .en     (win_q),
        .row    (cnt_q),
        .raw_re (row_re),
        .raw_im (row_im),
        .dout   (win_row)
    );

    for (genvar k = 0; k < N; k++) begin : g_fftin
        assign fft_in[k] = (state_q == S_ROW) ? win_row[k] : tbuf_q[k][cnt_q];
    end

    bf_fft8 u_fft (
        .scale (scale_q),
        .din   (fft_in),
        .dout  (fft_out)
    );

    // Transpose buffer: row results by row, then column results in place.
    always_ff @(posedge clk) begin
        if (state_q == S_ROW) begin
            for (int k = 0; k < N; k++) tbuf_q[cnt_q][k] <= fft_out[k];
        end else if (state_q == S_COL) begin
            for (int k = 0; k < N; k++) tbuf_q[k][cnt_q] <= fft_out[k];
        end
    end

    bf_beam_sel u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sel_we),
        .waddr (sel_addr),
        .wdata (sel_data),
        .raddr (cnt_q),
        .rdata (sel_idx)
    );

    assign beam = tbuf_q[sel_idx[EW-1:LOGN]][sel_idx[LOGN-1:0]];

    // Output register: one selected beam per cycle, then the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            frame_done <= 1'b0;
            out_re     <= '0;
            out_im     <= '0;
            out_index  <= '0;
        end else begin
            out_valid  <= (state_q == S_OUT);
            frame_done <= (state_q == S_DONE);
            if (state_q == S_OUT) begin
                out_re    <= beam.re;
                out_im    <= beam.im;
                out_index <= sel_idx;
            end
        end
    end
endmodule

// File: rtl/tile_beamformer_chk.sv
// Module: protocol checker for the beam output stream, bound to the top level.
// Watches only the output handshake and counts the length of each beam burst.
module tile_beamformer_chk
    import bf_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic frame_done
);
    logic [LOGN:0] run_q;

    // Burst length: consecutive cycles with out_valid high so far.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= out_valid ? run_q + 1'b1 : '0;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && !frame_done));

    // R2
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_q < (LOGN+1)'(N)));

    // R2
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (run_q == (LOGN+1)'(N) && frame_done));

    // R9
    done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!out_valid && $past(out_valid)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind tile_beamformer tile_beamformer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .frame_done (frame_done)
);

// File: tb/tile_beamformer_bench.sv
`timescale 1ns/1ps
// Bench: behavioural 2D DFT reference with a cycle-count model of the frame
// timeline, compared with the outputs on every falling edge.
module tile_beamformer_bench;
    import bf_pkg::*;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_valid = 1'b0;
    logic [NE*SW-1:0]   frame_re = '0;
    logic [NE*SW-1:0]   frame_im = '0;
    logic               win_en = 1'b0;
    logic               scale_en = 1'b0;
    logic               win_we = 1'b0;
    logic [EW-1:0]      win_addr = '0;
    logic [CW-1:0]      win_data = '0;
    logic               sel_we = 1'b0;
    logic [LOGN-1:0]    sel_addr = '0;
    logic [EW-1:0]      sel_data = '0;
    logic               out_valid;
    logic signed [DW-1:0] out_re, out_im;
    logic [EW-1:0]      out_index;
    logic               frame_done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Reference state
    int    win_b [NE];
    int    sel_b [N];
    bit    m_busy = 1'b0;
    int    m_t = -1;
    real   e_re [N];
    real   e_im [N];
    int    e_idx [N];
    real   m_tol = 8.0;
    string m_tag = "R4";
    string cur_tag = "R4";
    int unsigned lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    tile_beamformer u_tile_beamformer (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .frame_re(frame_re), .frame_im(frame_im),
        .win_en(win_en), .scale_en(scale_en),
        .win_we(win_we), .win_addr(win_addr), .win_data(win_data),
        .sel_we(sel_we), .sel_addr(sel_addr), .sel_data(sel_data),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im),
        .out_index(out_index), .frame_done(frame_done)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int samp(logic [NE*SW-1:0] v, int e);
        logic signed [SW-1:0] s;
        s = v[e*SW +: SW];
        return int'(s);
    endfunction

    // Behavioural 2D DFT of the accepted snapshot for every table entry.
    task automatic compute_expected();
        real pi2;
        pi2 = 6.283185307179586;
        for (int b = 0; b < N; b++) begin
            int kr, kc;
            e_idx[b] = sel_b[b];
            kr = sel_b[b] / N;
            kc = sel_b[b] % N;
            e_re[b] = 0.0;
            e_im[b] = 0.0;
            for (int r = 0; r < N; r++) begin
                for (int c = 0; c < N; c++) begin
                    int  xr, xi;
                    real ang;
                    xr = samp(frame_re, r*N + c);
                    xi = samp(frame_im, r*N + c);
                    if (win_en) begin
                        xr = (xr * win_b[r*N + c]) >>> 7;
                        xi = (xi * win_b[r*N + c]) >>> 7;
                    end
                    ang = -pi2 * real'(kr*r + kc*c) / 8.0;
                    e_re[b] += real'(xr) * $cos(ang) - real'(xi) * $sin(ang);
                    e_im[b] += real'(xr) * $sin(ang) + real'(xi) * $cos(ang);
                end
            end
            if (scale_en) begin
                e_re[b] = e_re[b] / 64.0;
                e_im[b] = e_im[b] / 64.0;
            end
        end
        m_tol = scale_en ? 6.0 : 8.0;
        m_tag = cur_tag;
    endtask

    // Timeline model: acceptance, 25 busy edges, ignore requests while busy (R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_t    = -1;
        end else if (m_busy) begin
            m_t++;
            if (m_t == 25) m_busy = 1'b0;
        end else if (frame_valid) begin
            m_busy = 1'b1;
            m_t    = 0;
            compute_expected();
        end else begin
            m_t = -1;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit ev, ed;
            ev = (m_t >= 17) && (m_t <= 24);
            ed = (m_t == 25);
            chk(out_valid == ev, "R2", "out_valid", int'(out_valid), int'(ev));
            chk(frame_done == ed, "R9", "frame_done", int'(frame_done), int'(ed));
            if (ev && out_valid) begin
                int  b, ar, ai;
                real dr, di;
                b  = m_t - 17;
                ar = int'(out_re);
                ai = int'(out_im);
                dr = real'(ar) - e_re[b];
                di = real'(ai) - e_im[b];
                if (dr < 0.0) dr = -dr;
                if (di < 0.0) di = -di;
                chk(out_index == EW'(e_idx[b]), "R3", "out_index", int'(out_index), e_idx[b]);
                chk(dr <= m_tol, m_tag, "beam real", ar, int'(e_re[b]));
                chk(di <= m_tol, m_tag, "beam imag", ai, int'(e_im[b]));
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_win(int e, int w);
        win_we = 1'b1; win_addr = EW'(e); win_data = CW'(w);
        tick(1);
        win_we = 1'b0;
        win_b[e] = w;
    endtask

    task automatic write_sel(int i, int idx);
        sel_we = 1'b1; sel_addr = LOGN'(i); sel_data = EW'(idx);
        tick(1);
        sel_we = 1'b0;
        sel_b[i] = idx;
    endtask

    task automatic load_sel(int a0, int a1, int a2, int a3, int a4, int a5, int a6, int a7);
        write_sel(0, a0); write_sel(1, a1); write_sel(2, a2); write_sel(3, a3);
        write_sel(4, a4); write_sel(5, a5); write_sel(6, a6); write_sel(7, a7);
    endtask

    task automatic set_impulse(int r, int c, int vr, int vi);
        frame_re = '0;
        frame_im = '0;
        frame_re[(r*N + c)*SW +: SW] = SW'(vr);
        frame_im[(r*N + c)*SW +: SW] = SW'(vi);
    endtask

    task automatic set_wave(int ar, int ac, real amp);
        for (int r = 0; r < N; r++) begin
            for (int c = 0; c < N; c++) begin
                real ang;
                ang = 6.283185307179586 * real'(ar*r + ac*c) / 8.0;
                frame_re[(r*N + c)*SW +: SW] = SW'(int'(amp * $cos(ang)));
                frame_im[(r*N + c)*SW +: SW] = SW'(int'(amp * $sin(ang)));
            end
        end
    endtask

    task automatic set_random();
        for (int e = 0; e < 2*NE; e++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            if (e < NE) frame_re[e*SW +: SW] = SW'((lcg >> 16) & 15);
            else        frame_im[(e-NE)*SW +: SW] = SW'((lcg >> 16) & 15);
        end
    endtask

    task automatic run_frame();
        frame_valid = 1'b1;
        tick(1);
        frame_valid = 1'b0;
        tick(30);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < NE; e++) win_b[e] = 128;
        for (int i = 0; i < N; i++) sel_b[i] = i;
        tick(5);
        rst_n = 1'b1;
        tick(1);

        // R1: idle outputs after reset
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(frame_done == 1'b0, "R1", "frame_done after reset", int'(frame_done), 0);

        // R1: default table and unity taper; corner impulse gives a flat spectrum
        cur_tag = "R1"; win_en = 1'b1; scale_en = 1'b0;
        set_impulse(0, 0, 5, -3);
        run_frame();

        // R8: reprogrammed table, off-corner impulse, no taper
        cur_tag = "R8"; win_en = 1'b0;
        load_sel(9, 63, 18, 0, 45, 27, 36, 54);
        set_impulse(2, 5, 7, 2);
        run_frame();

        // R4: plane waves, peak and neighbours
        cur_tag = "R4";
        load_sel(11, 0, 1, 8, 19, 59, 12, 10);
        set_wave(1, 3, 7.0);
        run_frame();
        load_sel(50, 49, 51, 42, 58, 2, 16, 63);
        set_wave(6, 2, 6.0);
        run_frame();

        // R7: position-dependent taper on a random snapshot
        cur_tag = "R7";
        for (int e = 0; e < NE; e++) write_win(e, (e * 4) % 256);
        win_en = 1'b1;
        set_random();
        load_sel(0, 7, 21, 33, 40, 47, 56, 62);
        run_frame();

        // R6: half-gain taper rounds each part down
        cur_tag = "R6";
        for (int e = 0; e < NE; e++) write_win(e, 64);
        load_sel(27, 26, 28, 19, 35, 0, 9, 36);
        set_wave(3, 3, 7.0);
        run_frame();
        set_random();
        run_frame();

        // R5: per-stage halving with near-double taper
        cur_tag = "R5";
        for (int e = 0; e < NE; e++) write_win(e, 255);
        scale_en = 1'b1;
        load_sel(22, 21, 23, 14, 30, 0, 45, 7);
        set_wave(2, 6, 7.0);
        run_frame();

        // R10: request held high, data changing every cycle; frames run back to back
        cur_tag = "R10"; scale_en = 1'b0; win_en = 1'b0;
        load_sel(5, 12, 19, 26, 33, 40, 47, 54);
        frame_valid = 1'b1;
        for (int k = 0; k < 60; k++) begin
            set_random();
            tick(1);
        end
        frame_valid = 1'b0;
        tick(35);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule